// File: doc/BRIEF.md
# Three-Source Interrupt Request Controller

This block collects interrupt events from three places: a synchronous external interrupt pin, a single-cycle overflow pulse from an 8-bit timer, and any change on a four-pin group of an input port. Each event sets a sticky flag in an 8-bit control byte. The byte also holds a per-source mask bit and a master enable. The control unit reads and writes the byte through a simple register port. When the master enable is set and any flag meets its own mask bit, the block raises a request toward the control unit.

The control unit accepts the request by pulsing an acknowledge. On that cycle the block asks for the current program counter to be pushed and presents the fixed vector address 0004h. On the next edge the master enable is cleared by hardware, which holds off nested entries. Only software clears flags. A return-from-interrupt strobe sets the master enable again. The pin group is compared with a copy captured on every port read, so a new value counts as a change until software reads the port.

Top module: `irq_ctrl_top`

## Requirements
- R1: While reset is asserted and on the first cycle after release, the control byte reads 00h and both `irqReq` and `pushReq` are low.
- R2: Control byte layout: bit 7 master enable, bit 6 always reads 0, bits 5/4/3 mask bits for timer/external/port-change, bits 2/1/0 flags for timer/external/port-change. A write is visible on `ctrlRd` one cycle later.
- R3: A high `timerOvf` in a cycle sets flag bit 2 on the next edge.
- R4: With `extRiseSel`=1 a 0-to-1 step of `extPin` between consecutive cycles sets flag bit 1, and with `extRiseSel`=0 a 1-to-0 step does so. The opposite step leaves bit 1 unchanged. The pin history resets to 0.
- R5: Flag bit 0 is set on each edge at which `portPins` differs from the copy taken on the last edge with `portRead` high. The copy resets to 0.
- R6: `irqReq` is high exactly when bit 7 is set and some flag bit n (n=0..2) has its mask bit n+3 set. Flags are still set while masked.
- R7: In a cycle with `irqAck` and `irqReq` both high, `pushReq` is high. Bit 7 reads 0 from the next cycle. `vecAddr` is always 0004h.
- R8: `irqAck` while `irqReq` is low has no effect: `pushReq` stays low and the master enable keeps its value.
- R9: Hardware never clears a flag. Without a register write, a flag that reads 1 still reads 1 next cycle, including across an accepted interrupt.
- R10: A write that clears a flag on the same edge as that flag's hardware set leaves the flag at 1.
- R11: `retIrq` sets bit 7 on the next edge. An accepted interrupt on the same edge wins, and the bit goes to 0. A return beats a register write to bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 1 | External interrupt pin, synchronous to clk |
| extRiseSel | input | 1 | 1: rising step on extPin counts, 0: falling step |
| timerOvf | input | 1 | Timer overflow pulse |
| portPins | input | 4 | Monitored port pin group |
| portRead | input | 1 | Port read strobe, captures the comparison copy |
| regWrEn | input | 1 | Control byte write strobe |
| regWrData | input | 8 | Control byte write data |
| ctrlRd | output | 8 | Control byte read value |
| irqReq | output | 1 | Interrupt request to control unit |
| irqAck | input | 1 | Control unit accepts the request |
| retIrq | input | 1 | Return-from-interrupt strobe |
| pushReq | output | 1 | Push current program counter |
| vecAddr | output | 13 | Interrupt vector address |

## Verification
The two functions that meet in one cycle are a software write to the control byte and a hardware update of the same byte. One case is a flag-clearing write on the edge where a timer pulse arrives. The other is a return strobe on the edge where an acknowledge is accepted. The bench drives both stimuli in one cycle. A behavioural reference model, stepped on every clock, predicts the byte and the request. The results are judged by reading the byte one cycle later, where the flag must stay set and the master enable must read 0.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CTRL_W   = 8;
  localparam int NUM_SRC  = 3;
  localparam int GIE_BIT  = 7;
  localparam int EN_LSB   = 3;
  localparam int FLAG_LSB = 0;
  localparam logic [CTRL_W-1:0] WR_MASK = 8'hBF;

  typedef struct packed {
    logic wrCtrl;
    logic takeIrq;
    logic setGie;
  } irq_strobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  irq_strobe_t         st,
  input  logic [CTRL_W-1:0]   wrData,
  input  logic                extPin,
  input  logic                extRiseSel,
  input  logic                timerOvf,
  input  logic [NIB_W-1:0]    portPins,
  input  logic                portRead,
  output logic [CTRL_W-1:0]   ctrlQ,
  output logic [NUM_SRC-1:0]  pendMask,
  output logic                gie
);
  logic [CTRL_W-1:0]  ctrlNext;
  logic [NIB_W-1:0]   portCopy;
  logic               extPrev;
  logic               extEdge;
  logic               portChg;
  logic [NUM_SRC-1:0] srcSet;

  assign extEdge = extRiseSel ? (extPin & ~extPrev) : (~extPin & extPrev);
  assign portChg = (portPins != portCopy);
  // source order matches flag bits: 2 timer, 1 external, 0 port change
  assign srcSet  = {timerOvf, extEdge, portChg};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    assign pendMask[g] = ctrlQ[FLAG_LSB+g] & ctrlQ[EN_LSB+g];
  end

  assign gie = ctrlQ[GIE_BIT];

  always_comb begin
    ctrlNext = ctrlQ;
    if (st.wrCtrl) ctrlNext = wrData & WR_MASK;
    if (st.takeIrq)     ctrlNext[GIE_BIT] = 1'b0;
    else if (st.setGie) ctrlNext[GIE_BIT] = 1'b1;
    ctrlNext[FLAG_LSB +: NUM_SRC] = ctrlNext[FLAG_LSB +: NUM_SRC] | srcSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      extPrev  <= 1'b0;
      portCopy <= '0;
    end else begin
      ctrlQ   <= ctrlNext;
      extPrev <= extPin;
      if (portRead) portCopy <= portPins;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               gie,
  input  logic [NUM_SRC-1:0] pendMask,
  input  logic               irqAck,
  input  logic               retIrq,
  input  logic               regWrEn,
  output irq_strobe_t        st,
  output logic               irqReq,
  output logic               pushReq
);
  assign irqReq     = gie & (|pendMask);
  assign st.takeIrq = irqAck & irqReq;
  assign st.setGie  = retIrq & ~st.takeIrq;
  assign st.wrCtrl  = regWrEn;
  assign pushReq    = st.takeIrq;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int VEC_W    = 13,
  parameter int VEC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              extRiseSel,
  input  logic              timerOvf,
  input  logic [NIB_W-1:0]  portPins,
  input  logic              portRead,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] ctrlRd,
  output logic              irqReq,
  input  logic              irqAck,
  input  logic              retIrq,
  output logic              pushReq,
  output logic [VEC_W-1:0]  vecAddr
);
  irq_strobe_t        st;
  logic [NUM_SRC-1:0] pendMask;
  logic               gie;

  irq_control u_ctrl (
    .gie(gie), .pendMask(pendMask), .irqAck(irqAck), .retIrq(retIrq),
    .regWrEn(regWrEn), .st(st), .irqReq(irqReq), .pushReq(pushReq)
  );

  irq_datapath #(.NIB_W(NIB_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(regWrData),
    .extPin(extPin), .extRiseSel(extRiseSel), .timerOvf(timerOvf),
    .portPins(portPins), .portRead(portRead),
    .ctrlQ(ctrlRd), .pendMask(pendMask), .gie(gie)
  );

  assign vecAddr = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timerOvf,
  input logic       regWrEn,
  input logic [7:0] ctrlRd,
  input logic       irqReq,
  input logic       irqAck,
  input logic       retIrq,
  input logic       pushReq
);
  // R3
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> ctrlRd[2]);
  // R6
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ctrlRd[7]);
  // R7
  entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |=> !ctrlRd[7]);
  // R8
  no_push_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqReq) |-> !pushReq);
  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((ctrlRd[2:0] & $past(ctrlRd[2:0])) == $past(ctrlRd[2:0])));
  // R11
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retIrq && !pushReq) |=> ctrlRd[7]);
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .timerOvf(timerOvf), .regWrEn(regWrEn),
  .ctrlRd(ctrlRd), .irqReq(irqReq), .irqAck(irqAck), .retIrq(retIrq),
  .pushReq(pushReq)
);

// File: tb/tb_irq_ctrl_top.sv
module tb_irq_ctrl_top;
  logic clk = 0;
  logic rstN = 0;
  logic extPin = 0, extRiseSel = 1, timerOvf = 0, portRead = 0;
  logic [3:0] portPins = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] ctrlRd;
  logic irqReq, irqAck = 0, retIrq = 0, pushReq;
  logic [12:0] vecAddr;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mReg = 0;
  logic       mPrev = 0;
  logic [3:0] mCopy = 0;

  always #2.5 clk = ~clk;

  irq_ctrl_top dut (.*);

  function automatic logic mReq();
    return mReg[7] && ((mReg[5] && mReg[2]) || (mReg[4] && mReg[1]) || (mReg[3] && mReg[0]));
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [7:0] n;
    logic req, edg;
    req = mReq();
    n = mReg;
    if (regWrEn) n = regWrData & 8'hBF;
    if (irqAck && req) n[7] = 0;
    else if (retIrq) n[7] = 1;
    edg = extRiseSel ? (extPin && !mPrev) : (!extPin && mPrev);
    if (timerOvf) n[2] = 1;
    if (edg) n[1] = 1;
    if (portPins != mCopy) n[0] = 1;
    if (portRead) mCopy = portPins;
    mPrev = extPin;
    mReg = n;
  endtask

  // compare outputs against model, then take one clock edge
  task automatic cyc(string tag);
    #1;
    chk(tag, "ctrlRd", ctrlRd, mReg);
    chk(tag, "irqReq", irqReq, mReq());
    chk(tag, "pushReq", pushReq, irqAck && mReq());
    chk("R7", "vecAddr", vecAddr, 4);
    @(posedge clk);
    if (rstN) modelStep();
    #1;
  endtask

  task automatic wr(logic [7:0] d, string tag);
    regWrEn = 1; regWrData = d; cyc(tag); regWrEn = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    // R1 reset state
    repeat (3) begin
      #1;
      chk("R1", "ctrlRd", ctrlRd, 0);
      chk("R1", "irqReq", irqReq, 0);
      chk("R1", "pushReq", pushReq, 0);
      @(posedge clk); #1;
    end
    rstN = 1;
    cyc("R1");
    // R2 layout and bit 6
    wr(8'h68, "R2"); cyc("R2");
    wr(8'hFF, "R2"); cyc("R2");
    wr(8'h00, "R2"); cyc("R2");
    // R3 timer pulse
    timerOvf = 1; cyc("R3"); timerOvf = 0; cyc("R3");
    wr(8'h00, "R3");
    // R4 external edges
    extPin = 1; cyc("R4"); cyc("R4");
    wr(8'h00, "R4");
    extPin = 0; cyc("R4"); cyc("R4");
    extRiseSel = 0;
    extPin = 1; cyc("R4"); cyc("R4");
    extPin = 0; cyc("R4"); cyc("R4");
    wr(8'h00, "R4"); cyc("R4");
    // R5 port change
    portPins = 4'hA; cyc("R5");
    portRead = 1; cyc("R5"); portRead = 0;
    wr(8'h00, "R5"); cyc("R5"); cyc("R5");
    portPins = 4'h3; cyc("R5"); cyc("R5");
    portRead = 1; cyc("R5"); portRead = 0;
    wr(8'h00, "R5"); cyc("R5");
    // R6 masked set, then request
    wr(8'h20, "R6");
    timerOvf = 1; cyc("R6"); timerOvf = 0; cyc("R6");
    wr(8'hA4, "R6"); cyc("R6");
    // R8 ack without request (mask cleared, gie kept)
    wr(8'h84, "R8"); irqAck = 1; cyc("R8"); irqAck = 0; cyc("R8");
    // R7 accepted entry, R9 flags kept
    wr(8'hA4, "R7"); irqAck = 1; cyc("R7"); irqAck = 0; cyc("R9"); cyc("R9");
    // R11 return restores enable
    retIrq = 1; cyc("R11"); retIrq = 0; cyc("R11");
    // R11 return and accept together: accept wins
    retIrq = 1; irqAck = 1; cyc("R11"); retIrq = 0; irqAck = 0; cyc("R11");
    // R11 return beats write to bit 7
    regWrEn = 1; regWrData = 8'h24; retIrq = 1; cyc("R11");
    regWrEn = 0; retIrq = 0; cyc("R11");
    // R10 write clear versus hardware set
    regWrEn = 1; regWrData = 8'h00; timerOvf = 1; cyc("R10");
    regWrEn = 0; timerOvf = 0; cyc("R10");
    portPins = 4'h0; extPin = 1;
    regWrEn = 1; regWrData = 8'h00; cyc("R10");
    regWrEn = 0; cyc("R10");
    // R9 hardware keeps flags across repeated acks
    wr(8'hBF, "R9"); irqAck = 1; cyc("R9"); irqAck = 0;
    repeat (3) cyc("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule